// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Controller

This block gives the two ports of a shared memory a way to signal each other. The top two words of the address space are reserved as mailboxes, one per port. When one port writes into the mailbox that belongs to the other port, the owner's interrupt is raised. The owner drops its interrupt by reading its own mailbox. The block only watches each port's enable, write strobe and address. The storage array and the meaning of the message belong to the surrounding memory.

Each port also supplies a busy input from the memory's contention arbiter. While a port is held busy, its accesses cannot raise the other side's interrupt and cannot clear its own. The interrupt outputs are active low. Each one is driven directly from a registered flag, so a qualifying access at one rising clock edge shows on the pin right after that edge.

Top module: `mbox_irq`

## Requirements
- R1: With address width AW, the right port's mailbox is at address 2^AW-1 and the left port's mailbox is at 2^AW-2. The default AW is 15, which places them at 7FFF and 7FFE.
- R2: A right-port write (rightEn=1, rightWe=1) to the left mailbox with rightBusy=0 sets the left flag. leftIntN is 0 after that clock edge.
- R3: A left-port write (leftEn=1, leftWe=1) to the right mailbox with leftBusy=0 sets the right flag. rightIntN is 0 after that clock edge.
- R4: A port's read (En=1, We=0) of its own mailbox with its busy at 0 clears that port's flag, and its interrupt output returns to 1 after the edge.
- R5: A port's read of the other port's mailbox changes neither interrupt output.
- R6: A write into the other port's mailbox while the writing port's busy is 1 leaves the target flag unchanged.
- R7: A read of a port's own mailbox while that port's busy is 1 leaves its flag unchanged.
- R8: While rstN=0 and after reset is released, both flags are clear, so leftIntN=1 and rightIntN=1.
- R9: When a set and a clear of the same flag occur in the same cycle, the flag is set.
- R10: Accesses with En=0, accesses to addresses other than the two mailboxes, and a port's write to its own mailbox leave both flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| leftEn | input | 1 | Left port access strobe for this cycle |
| leftWe | input | 1 | Left port write (1) or read (0) |
| leftAddr | input | AW | Left port word address |
| leftBusy | input | 1 | Left port held off by the arbiter |
| rightEn | input | 1 | Right port access strobe for this cycle |
| rightWe | input | 1 | Right port write (1) or read (0) |
| rightAddr | input | AW | Right port word address |
| rightBusy | input | 1 | Right port held off by the arbiter |
| leftIntN | output | 1 | Left port interrupt, active low |
| rightIntN | output | 1 | Right port interrupt, active low |

## Verification
The bench builds the block with AW=4, a 16-word space with the mailboxes at 15 and 14. At this size every address can be swept for each port, with each write/read choice and each busy value, starting from all four flag states. A second sweep drives both ports in the same cycle. It covers every enable, write and busy combination at the two mailboxes and at one ordinary address, which reaches the set-over-clear collision and busy-gated cases on both sides at once.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  typedef struct packed {
    logic setLeft;
    logic clrLeft;
    logic setRight;
    logic clrRight;
  } mboxStrobes_t;
endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int AW = 15
) (
  input  logic          leftEn,
  input  logic          leftWe,
  input  logic [AW-1:0] leftAddr,
  input  logic          leftBusy,
  input  logic          rightEn,
  input  logic          rightWe,
  input  logic [AW-1:0] rightAddr,
  input  logic          rightBusy,
  output mboxStrobes_t  strobes
);
  // R1: right box at the top word, left box one below
  localparam logic [AW-1:0] BoxRight = {AW{1'b1}};
  localparam logic [AW-1:0] BoxLeft  = {{(AW-1){1'b1}}, 1'b0};

  logic leftHitsLeftBox, leftHitsRightBox, rightHitsLeftBox, rightHitsRightBox;
  logic leftLive, rightLive;

  always_comb begin
    leftLive          = leftEn && !leftBusy;
    rightLive         = rightEn && !rightBusy;
    leftHitsLeftBox   = (leftAddr == BoxLeft);
    leftHitsRightBox  = (leftAddr == BoxRight);
    rightHitsLeftBox  = (rightAddr == BoxLeft);
    rightHitsRightBox = (rightAddr == BoxRight);

    strobes.setLeft  = rightLive && rightWe && rightHitsLeftBox;    // R2, R6
    strobes.setRight = leftLive && leftWe && leftHitsRightBox;      // R3, R6
    strobes.clrLeft  = leftLive && !leftWe && leftHitsLeftBox;      // R4, R7
    strobes.clrRight = rightLive && !rightWe && rightHitsRightBox;  // R4, R7
  end
endmodule

// File: rtl/mbox_flags.sv
module mbox_flags
  import mbox_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  mboxStrobes_t strobes,
  output logic         leftIntN,
  output logic         rightIntN
);
  localparam int Sides = 2;

  logic [Sides-1:0] setVec, clrVec, flagQ;

  assign setVec = {strobes.setRight, strobes.setLeft};
  assign clrVec = {strobes.clrRight, strobes.clrLeft};

  for (genvar s = 0; s < Sides; s++) begin : g_side
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          flagQ[s] <= 1'b0;
      else if (setVec[s]) flagQ[s] <= 1'b1;  // R9: set wins
      else if (clrVec[s]) flagQ[s] <= 1'b0;
    end

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
      setVec[s] |=> flagQ[s]);
    p_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
      (clrVec[s] && !setVec[s]) |=> !flagQ[s]);
    p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
      (!clrVec[s] && !setVec[s]) |=> $stable(flagQ[s]));
  end

  assign leftIntN  = ~flagQ[0];
  assign rightIntN = ~flagQ[1];
endmodule

// File: rtl/mbox_irq.sv
module mbox_irq
  import mbox_pkg::*;
#(
  parameter int AW = 15
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          leftEn,
  input  logic          leftWe,
  input  logic [AW-1:0] leftAddr,
  input  logic          leftBusy,
  input  logic          rightEn,
  input  logic          rightWe,
  input  logic [AW-1:0] rightAddr,
  input  logic          rightBusy,
  output logic          leftIntN,
  output logic          rightIntN
);
  localparam logic [AW-1:0] TopWord  = {AW{1'b1}};
  localparam logic [AW-1:0] NextWord = TopWord - 1'b1;

  mboxStrobes_t strobes;

  mbox_ctrl #(.AW(AW)) i_ctrl (
    .leftEn(leftEn), .leftWe(leftWe), .leftAddr(leftAddr), .leftBusy(leftBusy),
    .rightEn(rightEn), .rightWe(rightWe), .rightAddr(rightAddr), .rightBusy(rightBusy),
    .strobes(strobes)
  );

  mbox_flags i_flags (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .leftIntN(leftIntN), .rightIntN(rightIntN)
  );

  // Port-level checks
  p_right_raises_left_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rightEn && rightWe && !rightBusy && rightAddr == NextWord) |=> !leftIntN);
  p_left_raises_right_r3: assert property (@(posedge clk) disable iff (!rstN)
    (leftEn && leftWe && !leftBusy && leftAddr == TopWord) |=> !rightIntN);
  p_busy_blocks_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    (leftIntN && (!rightEn || rightBusy) && !(leftEn && !leftWe)) |=> leftIntN);
  p_busy_blocks_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!leftIntN && leftBusy) |=> !leftIntN);
  p_cross_read_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!rightIntN && !rightEn && leftEn && !leftWe && leftAddr == TopWord) |=> !rightIntN);
endmodule

// File: tb/test_mbox_irq.sv
`timescale 1ns/1ps
module test_mbox_irq;
  localparam int AW = 4;
  localparam logic [AW-1:0] MBR = AW'((1 << AW) - 1);
  localparam logic [AW-1:0] MBL = AW'((1 << AW) - 2);

  logic clk = 1'b0, rstN = 1'b0;
  logic leftEn = 0, leftWe = 0, leftBusy = 0, rightEn = 0, rightWe = 0, rightBusy = 0;
  logic [AW-1:0] leftAddr = '0, rightAddr = '0;
  logic leftIntN, rightIntN;
  int checks = 0, fails = 0;
  bit fL = 0, fR = 0, finished = 0;

  always #2.5 clk = ~clk;

  mbox_irq #(.AW(AW)) i_mbox_irq (.*);

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string pickTag(bit set, bit clr, bit blkS, bit blkC, bit xr, string setTag);
    if (set && clr) return "R9";
    if (set) return setTag;
    if (clr) return "R4";
    if (blkS) return "R6";
    if (blkC) return "R7";
    if (xr) return "R5";
    return "R10";
  endfunction

  // Called at a negedge; returns at the following negedge after checking.
  task automatic doOp(input bit lE, lW, input logic [AW-1:0] lA, input bit lB,
                      input bit rE, rW, input logic [AW-1:0] rA, input bit rB);
    bit sL, cL, sR, cR;
    string tL, tR;
    leftEn = lE; leftWe = lW; leftAddr = lA; leftBusy = lB;
    rightEn = rE; rightWe = rW; rightAddr = rA; rightBusy = rB;
    sL = rE && rW && rA == MBL && !rB;
    cL = lE && !lW && lA == MBL && !lB;
    sR = lE && lW && lA == MBR && !lB;
    cR = rE && !rW && rA == MBR && !rB;
    tL = pickTag(sL, cL, rE && rW && rA == MBL && rB, lE && !lW && lA == MBL && lB,
                 rE && !rW && rA == MBL, "R2");
    tR = pickTag(sR, cR, lE && lW && lA == MBR && lB, rE && !rW && rA == MBR && rB,
                 lE && !lW && lA == MBR, "R3");
    fL = sL ? 1'b1 : (cL ? 1'b0 : fL);
    fR = sR ? 1'b1 : (cR ? 1'b0 : fR);
    @(posedge clk);
    @(negedge clk);
    leftEn = 0; rightEn = 0;
    check({tL, " leftIntN (R1 map)"}, leftIntN, ~fL);
    check({tR, " rightIntN (R1 map)"}, rightIntN, ~fR);
  endtask

  task automatic establish(input bit wantL, input bit wantR);
    doOp(1, 0, MBL, 0, 1, 0, MBR, 0);          // owners read: clear both
    doOp(wantR, 1, MBR, 0, wantL, 1, MBL, 0);  // cross writes
  endtask

  function automatic logic [AW-1:0] pick(int i);
    return (i == 0) ? AW'(3) : ((i == 1) ? MBL : MBR);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R8 leftIntN in reset", leftIntN, 1'b1);
    check("R8 rightIntN in reset", rightIntN, 1'b1);
    rstN = 1'b1;
    @(negedge clk);
    check("R8 leftIntN after reset", leftIntN, 1'b1);
    check("R8 rightIntN after reset", rightIntN, 1'b1);

    // Single-port sweeps over every address
    for (int st = 0; st < 4; st++)
      for (int a = 0; a < (1 << AW); a++)
        for (int c = 0; c < 4; c++) begin
          establish(st[0], st[1]);
          doOp(1, c[0], AW'(a), c[1], 0, 0, '0, 0);
          establish(st[0], st[1]);
          doOp(0, 0, '0, 0, 1, c[0], AW'(a), c[1]);
        end

    // Concurrent sweep: enable/write/busy on both ports at key addresses
    for (int st = 0; st < 4; st++)
      for (int li = 0; li < 3; li++)
        for (int lc = 0; lc < 8; lc++)
          for (int ri = 0; ri < 3; ri++)
            for (int rc = 0; rc < 8; rc++) begin
              establish(st[0], st[1]);
              doOp(lc[0], lc[1], pick(li), lc[2], rc[0], rc[1], pick(ri), rc[2]);
            end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule